// File: doc/BRIEF.md
# Two-Wire Bus Slave Port with Host Status Flags

This block lets a host answer as a 7-bit-addressed slave on an I2C bus. It samples the open-drain clock and data lines with the system clock, finds START and STOP conditions, and shifts address and data bytes in and out. It acknowledges its own address and then either takes bytes from the master or sends bytes to it. The host works through four small registers: a one-byte data buffer, a read-only status word, a write-only control word and the slave address. An interrupt output rises once per completed byte.

When the master asks for data, the block stretches the clock. It holds SCL low until the host has put the next byte in the buffer and set the release bit. The master ends a read by not acknowledging the last byte. The block then takes that byte as the final one and raises no interrupt. A master that acknowledges every byte keeps the clock held after its last ACK. The host then loads a filler byte so that the master can regain the bus and issue a STOP.

Top module: `i2c_slave_stat`

## Requirements
- R1: A falling SDA while SCL is high is a START and sets status bit 3. A rising SDA while SCL is high is a STOP and sets status bit 4. Each condition clears the other's bit, so the two bits are never set together. Both bits are 0 after reset.
- R2: After a START, the first byte is compared in bits 7..1 with the own-address register (address 3, bits 6..0, reset value 0x2A). On a match the slave drives ACK (SDA low) in the ninth clock. On a mismatch it drives no ACK, raises no interrupt and ignores the bus until the next START or STOP.
- R3: Every acknowledged byte, address or data, is stored in the data buffer (address 0). It sets the buffer-full flag (status bit 0) and the interrupt flag (status bit 6, also the irq pin). A host read of address 0 clears buffer-full.
- R4: Status bit 2 is 0 when the last stored byte was an address and 1 when it was a data byte.
- R5: Status bit 1 equals bit 0 of the most recently stored byte. It changes with every stored data byte.
- R6: When a byte completes while buffer-full is still set, the slave does not acknowledge it and does not store it, and it sets the overflow flag (status bit 5). Writing control (address 2) with bit 2 set clears the overflow flag.
- R7: After a matched address with bit 0 = 1, the slave acknowledges and sets the interrupt flag. From the fall of the ninth clock it holds SCL low.
- R8: While SCL is held, the host writes the buffer and then writes control with bit 0 set. The slave releases SCL and sends the buffer MSB first. If the master acknowledges, the interrupt flag is set and SCL is held again after the ninth clock.
- R9: If the master does not acknowledge a sent byte, no interrupt flag is set and both lines stay released.
- R10: A STOP or a repeated START releases SDA and SCL. After a repeated START the next byte is matched as an address.
- R11: Writing control with bit 1 set clears the interrupt flag. After reset all status bits are 0 and neither line is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_addr | input | 2 | Host register select: 0 data, 1 status, 2 control, 3 own address |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe; side effect only on address 0 |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data, combinational from reg_addr |
| irq | output | 1 | Interrupt flag |

## Verification
The hardest state to reach is a held clock after a master ACK, followed by the ending the master is forced into. The master model must wait on the real SCL level while the host sequence runs between bytes. The bench therefore runs a read in which every byte is acknowledged. It loads an all-ones filler byte so that SDA stays released, and issues a STOP while that filler is being sent. The overflow NACK needs a host that deliberately leaves the buffer unread between two written bytes, so that case is scripted as well.

// File: rtl/i2cs_pkg.sv
// Shared definitions for the two-wire slave: bus state encoding,
// host register select values and status bit positions.
package i2cs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_HOLD,
        ST_TX,
        ST_TXACK
    } bus_state_t;

    localparam logic [1:0] SEL_DATA = 2'd0;
    localparam logic [1:0] SEL_STAT = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;
    localparam logic [1:0] SEL_OWN  = 2'd3;

    localparam int SB_FULL  = 0;
    localparam int SB_RW    = 1;
    localparam int SB_DATA  = 2;
    localparam int SB_START = 3;
    localparam int SB_STOP  = 4;
    localparam int SB_OVF   = 5;
    localparam int SB_IRQ   = 6;

    localparam int CB_RELEASE = 0;
    localparam int CB_CLR_IRQ = 1;
    localparam int CB_CLR_OVF = 2;
endpackage

// File: rtl/i2cs_line_sync.sv
// Synchronizes SCL/SDA into the system clock domain and derives clock
// edges and bus conditions. Assumes the bus is slow relative to clk
// (several samples per SCL phase). Reset value models an idle bus.
module i2cs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_q, sda_q;
    logic scl_d, sda_d, scl_s;

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    // Synchronizer chains plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // Conditions require SCL high in both samples so a coincident
    // SCL/SDA change is never taken for a START or STOP.
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2cs_bus_fsm.sv
// Bit/byte engine: shifts bytes, matches the address, drives ACK, holds
// SCL while waiting for the host and shifts transmit bytes. Emits
// single-cycle events to the register block. Assumes synchronized inputs.
module i2cs_bus_fsm
    import i2cs_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              buf_full,
    input  logic              release_req,
    input  logic [ADDR_W:0]   tx_byte,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              rx_valid,
    output logic [ADDR_W:0]   rx_byte,
    output logic              rx_is_addr,
    output logic              ovf_evt,
    output logic              tx_ack_evt
);
    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    bus_state_t        state;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              is_addr;
    logic              read_mode;

    // Main sequencer; START/STOP take priority over every state.
    always_ff @(posedge clk) begin
        rx_valid   <= 1'b0;
        ovf_evt    <= 1'b0;
        tx_ack_evt <= 1'b0;
        if (!rst_n) begin
            state      <= ST_IDLE;
            shreg      <= '0;
            cnt        <= '0;
            is_addr    <= 1'b0;
            read_mode  <= 1'b0;
            scl_oe     <= 1'b0;
            sda_oe     <= 1'b0;
            rx_byte    <= '0;
            rx_is_addr <= 1'b0;
        end else if (start_det) begin
            state     <= ST_RX;
            cnt       <= '0;
            is_addr   <= 1'b1;
            read_mode <= 1'b0;
            scl_oe    <= 1'b0;
            sda_oe    <= 1'b0;
        end else if (stop_det) begin
            state  <= ST_IDLE;
            scl_oe <= 1'b0;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (scl_rise && cnt < CNT_FULL) begin
                        shreg <= {shreg[BYTE_W-2:0], sda_s};
                        cnt   <= cnt + 1'b1;
                    end else if (scl_fall && cnt == CNT_FULL) begin
                        if (is_addr && shreg[BYTE_W-1:1] != own_addr) begin
                            state <= ST_IDLE;
                        end else if (buf_full) begin
                            ovf_evt <= 1'b1;
                            state   <= is_addr ? ST_IDLE : ST_ACK;
                        end else begin
                            sda_oe     <= 1'b1;
                            rx_valid   <= 1'b1;
                            rx_byte    <= shreg;
                            rx_is_addr <= is_addr;
                            if (is_addr) read_mode <= shreg[0];
                            state      <= ST_ACK;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        sda_oe  <= 1'b0;
                        cnt     <= '0;
                        is_addr <= 1'b0;
                        if (read_mode) begin
                            scl_oe <= 1'b1;
                            state  <= ST_HOLD;
                        end else begin
                            state <= ST_RX;
                        end
                    end
                end
                ST_HOLD: begin
                    if (release_req) begin
                        shreg  <= tx_byte;
                        sda_oe <= ~tx_byte[BYTE_W-1];
                        scl_oe <= 1'b0;
                        cnt    <= '0;
                        state  <= ST_TX;
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (cnt == CNT_LAST) begin
                            sda_oe <= 1'b0;
                            state  <= ST_TXACK;
                        end else begin
                            shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~shreg[BYTE_W-2];
                            cnt    <= cnt + 1'b1;
                        end
                    end
                end
                ST_TXACK: begin
                    if (scl_rise) begin
                        if (!sda_s) begin
                            tx_ack_evt <= 1'b1;
                            state      <= ST_ACK;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R7: SCL is pulled low for as long as the host is awaited.
    a_r7_hold_drives_scl: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> scl_oe);
    // R6: an overflow event only follows a cycle with the buffer full.
    a_r6_ovf_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |-> $past(buf_full));
    // R10: idle means neither line is driven.
    a_r10_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!scl_oe && !sda_oe));
    // R9: master NACK gives no interrupt event and returns to idle.
    a_r9_nack_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TXACK && scl_rise && sda_s && !start_det && !stop_det)
        |=> (!tx_ack_evt && state == ST_IDLE));
endmodule

// File: rtl/i2cs_host_regs.sv
// Host-visible registers: data buffer, status flags, control strobes and
// own address. Reads are combinational; only a read of the data register
// has a side effect (clears buffer-full).
module i2cs_host_regs
    import i2cs_pkg::*;
#(
    parameter int          ADDR_W   = 7,
    parameter logic [ADDR_W-1:0] OWN_RST = 7'h2A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W:0]   reg_wdata,
    output logic [ADDR_W:0]   reg_rdata,
    input  logic              rx_valid,
    input  logic [ADDR_W:0]   rx_byte,
    input  logic              rx_is_addr,
    input  logic              ovf_evt,
    input  logic              tx_ack_evt,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              irq,
    output logic              buf_full,
    output logic              release_req,
    output logic [ADDR_W:0]   tx_byte,
    output logic [ADDR_W-1:0] own_addr
);
    localparam int BYTE_W = ADDR_W + 1;

    logic [BYTE_W-1:0] data_buf;
    logic st_rw, st_data, st_start, st_stop, st_ovf;
    logic wr_data, wr_ctrl, wr_own, rd_data;
    logic [BYTE_W-1:0] status;

    assign wr_data = reg_wr && reg_addr == SEL_DATA;
    assign wr_ctrl = reg_wr && reg_addr == SEL_CTRL;
    assign wr_own  = reg_wr && reg_addr == SEL_OWN;
    assign rd_data = reg_rd && reg_addr == SEL_DATA;
    assign tx_byte = data_buf;

    // Data buffer and own address storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_buf <= '0;
            own_addr <= OWN_RST;
        end else begin
            if (rx_valid)      data_buf <= rx_byte;
            else if (wr_data)  data_buf <= reg_wdata;
            if (wr_own)        own_addr <= reg_wdata[ADDR_W-1:0];
        end
    end

    // Status flags; set events win over host clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_full <= 1'b0;
            st_rw    <= 1'b0;
            st_data  <= 1'b0;
            st_start <= 1'b0;
            st_stop  <= 1'b0;
            st_ovf   <= 1'b0;
            irq      <= 1'b0;
        end else begin
            if (rx_valid) begin
                buf_full <= 1'b1;
                st_rw    <= rx_byte[0];
                st_data  <= ~rx_is_addr;
            end else if (rd_data) begin
                buf_full <= 1'b0;
            end
            if (start_det) begin
                st_start <= 1'b1;
                st_stop  <= 1'b0;
            end else if (stop_det) begin
                st_start <= 1'b0;
                st_stop  <= 1'b1;
            end
            if (ovf_evt)                              st_ovf <= 1'b1;
            else if (wr_ctrl && reg_wdata[CB_CLR_OVF]) st_ovf <= 1'b0;
            if (rx_valid || tx_ack_evt)               irq <= 1'b1;
            else if (wr_ctrl && reg_wdata[CB_CLR_IRQ]) irq <= 1'b0;
        end
    end

    // Clock-release strobe towards the bus engine.
    always_ff @(posedge clk) begin
        if (!rst_n) release_req <= 1'b0;
        else        release_req <= wr_ctrl && reg_wdata[CB_RELEASE];
    end

    // Host read multiplexer.
    always_comb begin
        status           = '0;
        status[SB_FULL]  = buf_full;
        status[SB_RW]    = st_rw;
        status[SB_DATA]  = st_data;
        status[SB_START] = st_start;
        status[SB_STOP]  = st_stop;
        status[SB_OVF]   = st_ovf;
        status[SB_IRQ]   = irq;
        case (reg_addr)
            SEL_DATA: reg_rdata = data_buf;
            SEL_STAT: reg_rdata = status;
            SEL_OWN:  reg_rdata = {1'b0, own_addr};
            default:  reg_rdata = '0;
        endcase
    end

    a_r1_start_stop_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_start && st_stop));
    a_r3_read_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !rx_valid) |=> !buf_full);
    a_r3_byte_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> (buf_full && irq));
    a_r8_ack_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ack_evt |=> irq);
endmodule

// File: rtl/i2c_slave_stat.sv
// Top level of the 7-bit-address two-wire slave with host status flags.
// Lines are open drain: an *_oe of 1 means pull low. Assumes the bus
// clock phases last several system clocks.
module i2c_slave_stat #(
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] OWN_ADDR    = 7'h2A
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe,
    output logic       sda_oe,
    input  logic [1:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq
);
    localparam int ADDR_W = 7;

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic buf_full, release_req, rx_valid, rx_is_addr, ovf_evt, tx_ack_evt;
    logic [ADDR_W:0]   rx_byte, tx_byte;
    logic [ADDR_W-1:0] own_addr;

    i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2cs_bus_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .own_addr(own_addr), .buf_full(buf_full),
        .release_req(release_req), .tx_byte(tx_byte),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rx_is_addr(rx_is_addr),
        .ovf_evt(ovf_evt), .tx_ack_evt(tx_ack_evt)
    );

    i2cs_host_regs #(.ADDR_W(ADDR_W), .OWN_RST(OWN_ADDR)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_is_addr(rx_is_addr),
        .ovf_evt(ovf_evt), .tx_ack_evt(tx_ack_evt),
        .start_det(start_det), .stop_det(stop_det),
        .irq(irq), .buf_full(buf_full), .release_req(release_req),
        .tx_byte(tx_byte), .own_addr(own_addr)
    );
endmodule

// File: tb/i2c_slave_stat_tb.sv
// Bench: an open-drain master model, a host model and a status reference
// that is compared on every clock while the bus is quiet.
module i2c_slave_stat_tb;
    localparam int Q = 5;
    localparam logic [1:0] A_DATA = 2'd0, A_STAT = 2'd1, A_CTRL = 2'd2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_oe, sda_oe, irq;
    logic [1:0] reg_addr = A_STAT;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00, reg_rdata;
    logic scl_bus, sda_bus;

    int total = 0, bad = 0;
    logic [7:0] exp_stat = 8'h00;
    bit exp_valid = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign scl_bus = scl_m & ~scl_oe;
    assign sda_bus = sda_m & ~sda_oe;

    i2c_slave_stat u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [7:0] st(bit full, bit rw, bit dat, bit sta,
                                      bit sto, bit ovf, bit ir);
        return {1'b0, ir, ovf, sto, sta, dat, rw, full};
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference status compared each clock, away from both edges.
    always @(posedge clk) begin
        #5;
        if (rst_n && exp_valid && reg_addr == A_STAT && !done)
            chk("R1/R3/R4/R5 monitor", reg_rdata, exp_stat);
    end

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_status(string req, logic [7:0] exp);
        @(negedge clk);
        #1;
        chk(req, reg_rdata, exp);
        exp_stat  = exp;
        exp_valid = 1'b1;
    endtask

    task automatic host_wr(logic [1:0] a, logic [7:0] d);
        exp_valid = 1'b0;
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = A_STAT;
    endtask

    task automatic host_rd(logic [1:0] a, output logic [7:0] d);
        exp_valid = 1'b0;
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0; reg_addr = A_STAT;
    endtask

    task automatic bus_bit(bit b, output bit r);
        wait_clk(Q); sda_m = b;
        wait_clk(Q); scl_m = 1'b1;
        while (scl_bus !== 1'b1) @(negedge clk);
        wait_clk(Q); r = sda_bus;
        wait_clk(Q); scl_m = 1'b0;
    endtask

    task automatic m_start();
        exp_valid = 1'b0;
        sda_m = 1'b1; scl_m = 1'b1;
        wait_clk(2*Q); sda_m = 1'b0;
        wait_clk(2*Q); scl_m = 1'b0;
    endtask

    task automatic m_rstart();
        exp_valid = 1'b0;
        wait_clk(Q); sda_m = 1'b1;
        wait_clk(Q); scl_m = 1'b1;
        while (scl_bus !== 1'b1) @(negedge clk);
        wait_clk(2*Q); sda_m = 1'b0;
        wait_clk(2*Q); scl_m = 1'b0;
    endtask

    task automatic m_stop();
        exp_valid = 1'b0;
        wait_clk(Q); sda_m = 1'b0;
        wait_clk(Q); scl_m = 1'b1;
        while (scl_bus !== 1'b1) @(negedge clk);
        wait_clk(2*Q); sda_m = 1'b1;
        wait_clk(4*Q);
    endtask

    task automatic m_write(logic [7:0] b, output bit nack);
        bit r;
        exp_valid = 1'b0;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], r);
        bus_bit(1'b1, nack);
        wait_clk(4*Q);
    endtask

    task automatic m_read(bit give_nack, output logic [7:0] v);
        bit r;
        exp_valid = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, r);
            v[i] = r;
        end
        bus_bit(give_nack, r);
        wait_clk(4*Q);
    endtask

    // Host service after an address or data byte: read buffer, clear irq.
    task automatic take_byte(string req, logic [7:0] exp);
        logic [7:0] d;
        host_rd(A_DATA, d);
        chk(req, d, exp);
        host_wr(A_CTRL, 8'h02);
    endtask

    task automatic send_next(logic [7:0] b);
        host_wr(A_DATA, b);
        host_wr(A_CTRL, 8'h01);
    endtask

    initial begin
        bit nk;
        logic [7:0] v, d;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        // R11: reset state
        check_status("R11 reset status", 8'h00);
        chk("R11 reset lines", {6'd0, scl_oe, sda_oe}, 8'h00);
        chk("R11 reset irq", {7'd0, irq}, 8'h00);

        // Write transfer
        m_start();
        check_status("R1 start bit", st(0,0,0,1,0,0,0));
        m_write(8'h54, nk);
        chk("R2 address ack", {7'd0, nk}, 8'h00);
        check_status("R3 R4 R5 after address", st(1,0,0,1,0,0,1));
        chk("R3 irq pin", {7'd0, irq}, 8'h01);
        take_byte("R3 address in buffer", 8'h54);
        check_status("R3 R11 cleared", st(0,0,0,1,0,0,0));
        m_write(8'hA5, nk);
        chk("R3 data ack", {7'd0, nk}, 8'h00);
        check_status("R4 R5 data A5", st(1,1,1,1,0,0,1));
        take_byte("R3 data A5", 8'hA5);
        m_write(8'h3C, nk);
        check_status("R5 data 3C", st(1,0,1,1,0,0,1));
        take_byte("R3 data 3C", 8'h3C);
        m_stop();
        check_status("R1 stop bit", st(0,0,1,0,1,0,0));

        // Foreign address is ignored
        m_start();
        m_write(8'h26, nk);
        chk("R2 mismatch nack", {7'd0, nk}, 8'h01);
        m_write(8'h55, nk);
        chk("R2 ignored byte nack", {7'd0, nk}, 8'h01);
        check_status("R2 no flags", st(0,0,1,1,0,0,0));
        m_stop();

        // Overflow
        m_start();
        m_write(8'h54, nk);
        take_byte("R3 overflow address", 8'h54);
        m_write(8'h11, nk);
        chk("R6 first ack", {7'd0, nk}, 8'h00);
        host_wr(A_CTRL, 8'h02);
        m_write(8'h22, nk);
        chk("R6 overflow nack", {7'd0, nk}, 8'h01);
        check_status("R6 overflow flag", st(1,1,1,1,0,1,0));
        host_rd(A_DATA, d);
        chk("R6 buffer kept", d, 8'h11);
        host_wr(A_CTRL, 8'h04);
        check_status("R6 overflow cleared", st(0,1,1,1,0,0,0));
        m_stop();

        // Read, final NACK
        m_start();
        m_write(8'h55, nk);
        chk("R7 read address ack", {7'd0, nk}, 8'h00);
        chk("R7 scl held", {7'd0, scl_oe}, 8'h01);
        check_status("R7 status", st(1,1,0,1,0,0,1));
        take_byte("R7 address in buffer", 8'h55);
        send_next(8'hC3);
        m_read(1'b0, v);
        chk("R8 byte C3", v, 8'hC3);
        chk("R8 irq after ack", {7'd0, irq}, 8'h01);
        chk("R8 scl held again", {7'd0, scl_oe}, 8'h01);
        host_wr(A_CTRL, 8'h02);
        send_next(8'h5A);
        m_read(1'b1, v);
        chk("R8 byte 5A", v, 8'h5A);
        chk("R9 no irq", {7'd0, irq}, 8'h00);
        chk("R9 lines free", {6'd0, scl_oe, sda_oe}, 8'h00);
        m_stop();

        // Read, master ACKs everything; filler then STOP
        m_start();
        m_write(8'h55, nk);
        take_byte("R7 second read", 8'h55);
        for (int k = 0; k < 3; k++) begin
            logic [7:0] b;
            b = (k == 0) ? 8'h81 : (k == 1) ? 8'h7E : 8'h00;
            send_next(b);
            m_read(1'b0, v);
            chk("R8 streamed byte", v, b);
            chk("R8 streamed irq", {7'd0, irq}, 8'h01);
            host_wr(A_CTRL, 8'h02);
        end
        chk("R8 held after last ack", {7'd0, scl_oe}, 8'h01);
        send_next(8'hFF);
        m_stop();
        chk("R10 stop releases", {6'd0, scl_oe, sda_oe}, 8'h00);
        check_status("R10 R1 stop status", st(0,1,0,0,1,0,0));

        // Repeated START switches to read
        m_start();
        m_write(8'h54, nk);
        take_byte("R10 write addr", 8'h54);
        m_write(8'h99, nk);
        take_byte("R10 data 99", 8'h99);
        m_rstart();
        check_status("R10 R1 rstart", st(0,1,1,1,0,0,0));
        m_write(8'h55, nk);
        chk("R10 re-address ack", {7'd0, nk}, 8'h00);
        check_status("R10 R4 readdress", st(1,1,0,1,0,0,1));
        take_byte("R10 read addr", 8'h55);
        send_next(8'h42);
        m_read(1'b1, v);
        chk("R10 byte 42", v, 8'h42);
        m_stop();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule